// File: doc/BRIEF.md
# Command/Address Packet Encoder

This block sits on the controller side of a DRAM command/address interface. It takes one abstract memory command (row open, column read, column write, row close, refresh or mode-register write) together with its bank, row, column and mode-register fields. It serialises the command into a two-beat packet on an 8-bit command/address bus, framed by a clock-enable line that is high for exactly the two beats of each packet.

Requests arrive on a valid/ready handshake. The encoder accepts a request only on a beat boundary, that is, while the bus is idle or while beat 1 of the previous packet is being driven. Packets can therefore follow each other with no idle cycle between them. While no packet is being sent, the bus carries all zeros and clock-enable is low, so the receiver decodes nothing. Clock-enable never drops between the two beats of one packet, because the receiver restarts its beat count whenever clock-enable falls.

A row-open command whose row does not fit the 9-bit row field is not sent. Instead it raises a one-cycle error flag.

Top module: `ca_pkt_encoder`

## Requirements
- R1: After reset, ca_o is 0, cke_o is 0, req_ready_o is 1 and row_err_o is 0.
- R2: A request accepted at a clock edge (req_valid_i and req_ready_o both high) drives beat 0 with cke_o high in the next cycle and beat 1 with cke_o high in the cycle after. A request accepted during beat 1 follows with no idle cycle.
- R3: Beat 0 bits [7:6] carry the class and bit 5 the sub-code. The class codes are 00 for row open, 01 for read and write, 10 for row close and refresh, and 11 for mode-register write. Bit 5 is 0 for read and 1 for write; it is 0 for row close and 1 for refresh. Command codes on req_cmd_i: 0 row open, 1 read, 2 write, 3 row close, 4 refresh, 5 mode-register write.
- R4: For row open, read, write and row close, beat 0 bits [4:0] carry the bank. Row close and refresh send beat 1 as 0. Refresh sends beat 0 bits [4:0] as 0.
- R5: For read and write, beat 1 is {2'b00, column[5:0]}.
- R6: For row open, beat 0 bit 5 is row bit 8 and beat 1 is row[7:0].
- R7: A row-open request with row above 511 is accepted. It sends no packet, and row_err_o is high for the one cycle after acceptance.
- R8: For mode-register write, beat 0 is {2'b11, 2'b00, data[7:4]} and beat 1 is {data[3:0], 1'b0, address[2:0]}.
- R9: Whenever cke_o is low, ca_o is all zeros.
- R10: req_ready_o is low exactly during the beat-0 cycle of a packet and high in every other cycle.
- R11: Requests with command codes 6 or 7 are accepted and dropped. No packet is sent and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Encoder can accept a request at this edge |
| req_cmd_i | input | 3 | Command code |
| req_bank_i | input | 5 | Bank number |
| req_row_i | input | ROW_W (14) | Row address for row open |
| req_col_i | input | 6 | Column address for read and write |
| req_mr_addr_i | input | 3 | Mode-register address |
| req_mr_data_i | input | 8 | Mode-register data |
| ca_o | output | 8 | Command/address bus |
| cke_o | output | 1 | Clock-enable framing the packet beats |
| row_err_o | output | 1 | One-cycle pulse for a rejected out-of-range row |

## Verification
A sequencer stuck in the wrong beat phase shows up within one cycle. It appears either as ready low while clock-enable is low, or as a lone clock-enable beat that leaves the receiver's beat count misaligned; from then on every following packet decodes as garbage. A stale beat-1 register or a swapped field only shows when the packet is compared beat by beat against the expected packing, and that comparison is made in the cycle the beat appears. An out-of-range row that leaks onto the bus is visible two cycles after acceptance, as a packet where none is expected.

// File: rtl/ca_pkt_pkg.sv
package ca_pkt_pkg;
  localparam int CA_W      = 8;
  localparam int BANK_W    = 5;
  localparam int COL_W     = 6;
  localparam int MRA_W     = 3;
  localparam int MRD_W     = 8;
  localparam int ACT_ROW_W = 9;  // row bits the packet can carry
  localparam int CMD_W     = 3;

  localparam logic [CMD_W-1:0] CMD_ACT = 3'd0;
  localparam logic [CMD_W-1:0] CMD_RD  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_WR  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'd3;
  localparam logic [CMD_W-1:0] CMD_REF = 3'd4;
  localparam logic [CMD_W-1:0] CMD_MRW = 3'd5;

  localparam logic [1:0] CLS_ACT = 2'b00;
  localparam logic [1:0] CLS_COL = 2'b01;
  localparam logic [1:0] CLS_ROW = 2'b10;
  localparam logic [1:0] CLS_MRW = 2'b11;

  typedef struct packed {
    logic [CA_W-1:0] b0;
    logic [CA_W-1:0] b1;
  } pkt_t;
endpackage

// File: rtl/ca_beat_packer.sv
module ca_beat_packer
  import ca_pkt_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MRA_W-1:0]  mr_addr_i,
  input  logic [MRD_W-1:0]  mr_data_i,
  output pkt_t              pkt_o,
  output logic              send_o,
  output logic              row_bad_o
);
  logic row_high;

  generate
    if (ROW_W > ACT_ROW_W) begin : g_row_chk
      assign row_high = |row_i[ROW_W-1:ACT_ROW_W];
    end else begin : g_row_fits
      assign row_high = 1'b0;
    end
  endgenerate

  logic [ACT_ROW_W-1:0] row_lo;
  assign row_lo = ACT_ROW_W'(row_i);

  always_comb begin
    pkt_o     = '0;
    send_o    = 1'b1;
    row_bad_o = 1'b0;
    unique case (cmd_i)
      CMD_ACT: begin
        pkt_o.b0  = {CLS_ACT, row_lo[8], bank_i};
        pkt_o.b1  = row_lo[7:0];
        row_bad_o = row_high;
        send_o    = !row_high;
      end
      CMD_RD:  begin
        pkt_o.b0 = {CLS_COL, 1'b0, bank_i};
        pkt_o.b1 = {2'b00, col_i};
      end
      CMD_WR:  begin
        pkt_o.b0 = {CLS_COL, 1'b1, bank_i};
        pkt_o.b1 = {2'b00, col_i};
      end
      CMD_PRE: pkt_o.b0 = {CLS_ROW, 1'b0, bank_i};
      CMD_REF: pkt_o.b0 = {CLS_ROW, 1'b1, 5'd0};
      CMD_MRW: begin
        pkt_o.b0 = {CLS_MRW, 2'b00, mr_data_i[7:4]};
        pkt_o.b1 = {mr_data_i[3:0], 1'b0, mr_addr_i};
      end
      default: send_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ca_beat_seq.sv
module ca_beat_seq
  import ca_pkt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            send_i,
  input  logic            row_bad_i,
  input  pkt_t            pkt_i,
  output logic [CA_W-1:0] ca_o,
  output logic            cke_o,
  output logic            beat0_o,
  output logic            err_o
);
  logic            beat0_q;
  logic [CA_W-1:0] b1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat0_q <= 1'b0;
      b1_q    <= '0;
      ca_o    <= '0;
      cke_o   <= 1'b0;
      err_o   <= 1'b0;
    end else if (beat0_q) begin
      // second beat always follows, cke held high
      beat0_q <= 1'b0;
      ca_o    <= b1_q;
      cke_o   <= 1'b1;
      err_o   <= 1'b0;
    end else begin
      err_o <= accept_i && row_bad_i;
      if (accept_i && send_i) begin
        beat0_q <= 1'b1;
        ca_o    <= pkt_i.b0;
        b1_q    <= pkt_i.b1;
        cke_o   <= 1'b1;
      end else begin
        ca_o  <= '0;
        cke_o <= 1'b0;
      end
    end
  end

  assign beat0_o = beat0_q;
endmodule

// File: rtl/ca_pkt_encoder.sv
module ca_pkt_encoder
  import ca_pkt_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_cmd_i,
  input  logic [4:0]       req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [5:0]       req_col_i,
  input  logic [2:0]       req_mr_addr_i,
  input  logic [7:0]       req_mr_data_i,
  output logic [7:0]       ca_o,
  output logic             cke_o,
  output logic             row_err_o
);
  pkt_t pkt;
  logic send, row_bad, beat0, accept;

  assign req_ready_o = !beat0;
  assign accept      = req_valid_i && req_ready_o;

  ca_beat_packer #(.ROW_W(ROW_W)) i_packer (
    .cmd_i     (req_cmd_i),
    .bank_i    (req_bank_i),
    .row_i     (req_row_i),
    .col_i     (req_col_i),
    .mr_addr_i (req_mr_addr_i),
    .mr_data_i (req_mr_data_i),
    .pkt_o     (pkt),
    .send_o    (send),
    .row_bad_o (row_bad)
  );

  ca_beat_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .send_i    (send),
    .row_bad_i (row_bad),
    .pkt_i     (pkt),
    .ca_o      (ca_o),
    .cke_o     (cke_o),
    .beat0_o   (beat0),
    .err_o     (row_err_o)
  );
endmodule

// File: rtl/ca_pkt_encoder_chk.sv
module ca_pkt_encoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic [7:0] ca_o,
  input logic       cke_o,
  input logic       row_err_o
);
  p_beat1_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (cke_o && req_ready_o));

  p_rise_is_beat0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> !req_ready_o);

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (ca_o == 8'd0));

  p_ready_beat0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> cke_o);

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_err_o |-> !cke_o);
endmodule

bind ca_pkt_encoder ca_pkt_encoder_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .ca_o        (ca_o),
  .cke_o       (cke_o),
  .row_err_o   (row_err_o)
);

// File: tb/test_ca_pkt_encoder.sv
`timescale 1ns/1ps
module test_ca_pkt_encoder;
  localparam int ROW_W = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_cmd = '0;
  logic [4:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic [2:0] req_mra = '0;
  logic [7:0] req_mrd = '0;
  logic [7:0] ca;
  logic cke, row_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // item: {is_err, b0, b1}
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  mon_b0;
  bit          mon_in_b1 = 1'b0;

  always #2 clk = ~clk;

  ca_pkt_encoder #(.ROW_W(ROW_W)) i_ca_pkt_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_mr_addr_i(req_mra), .req_mr_data_i(req_mrd), .ca_o(ca), .cke_o(cke),
    .row_err_o(row_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected packing taken from the requirement text
  task automatic send(input logic [2:0] cmd, input logic [4:0] bank, input logic [ROW_W-1:0] row,
                      input logic [5:0] col, input logic [2:0] mra, input logic [7:0] mrd,
                      input string tag);
    logic [7:0] b0, b1;
    bit tx, er;
    b0 = '0; b1 = '0; tx = 1'b1; er = 1'b0;
    case (cmd)
      3'd0: if (row > 511) begin tx = 1'b0; er = 1'b1; end
            else begin b0 = {2'b00, row[8], bank}; b1 = row[7:0]; end
      3'd1: begin b0 = {2'b01, 1'b0, bank}; b1 = {2'b00, col}; end
      3'd2: begin b0 = {2'b01, 1'b1, bank}; b1 = {2'b00, col}; end
      3'd3: b0 = {2'b10, 1'b0, bank};
      3'd4: b0 = 8'b1010_0000;
      3'd5: begin b0 = {2'b11, 2'b00, mrd[7:4]}; b1 = {mrd[3:0], 1'b0, mra}; end
      default: tx = 1'b0;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_bank = bank; req_row = row;
    req_col = col; req_mra = mra; req_mrd = mrd;
    while (!req_ready) @(negedge clk);
    if (tx || er) begin
      exp_q.push_back({er, b0, b1});
      tag_q.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (!cke) chk(ca == 8'd0, "R9 idle bus", ca, 0);
      if (!req_ready) chk(cke && !mon_in_b1, "R10 ready low only in beat0", {cke, mon_in_b1}, 2'b10);
      if (row_err) begin
        if (exp_q.size() != 0 && exp_q[0][16]) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
          chk(!cke, "R7 no packet with error", cke, 0);
        end else chk(1'b0, "R7 unexpected row_err", 1, 0);
      end
      if (cke) begin
        if (!mon_in_b1) begin
          mon_b0 = ca;
          mon_in_b1 = 1'b1;
        end else begin
          mon_in_b1 = 1'b0;
          if (exp_q.size() == 0 || exp_q[0][16]) begin
            chk(1'b0, "R11 unexpected packet", {mon_b0, ca}, 0);
          end else begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk({mon_b0, ca} == e[15:0], t, {mon_b0, ca}, e[15:0]);
          end
        end
      end else if (mon_in_b1) begin
        chk(1'b0, "R2 cke dropped after beat0", 0, 1);
        mon_in_b1 = 1'b0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ca == 0 && !cke && req_ready && !row_err, "R1 reset state",
        {ca, cke, req_ready, row_err}, {8'd0, 3'b010});
    rst_ni = 1'b1;
    idle(2);

    send(3'd0, 5'd5, 14'h1A5, 6'd0, 3'd0, 8'd0, "R6 R3 row open bank5 row 0x1A5");
    idle(3);
    send(3'd0, 5'd17, 14'h04C, 6'd0, 3'd0, 8'd0, "R6 row open row8=0");
    // back-to-back column commands
    send(3'd1, 5'd31, '0, 6'd63, 3'd0, 8'd0, "R5 R3 read bank31 col63");
    send(3'd2, 5'd0, '0, 6'd21, 3'd0, 8'd0, "R5 R2 write back-to-back");
    send(3'd3, 5'd9, 14'h3FFF & 14'h0, 6'd44, 3'd0, 8'd0, "R4 row close bank9");
    send(3'd4, 5'd22, '0, 6'd7, 3'd5, 8'hFF, "R4 refresh");
    idle(2);
    send(3'd5, 5'd3, '0, 6'd0, 3'd7, 8'hC3, "R8 mode write addr7 0xC3");
    send(3'd5, 5'd0, '0, 6'd0, 3'd0, 8'h5A, "R8 mode write addr0 0x5A");
    idle(2);
    send(3'd0, 5'd2, 14'd512, 6'd0, 3'd0, 8'd0, "R7 row 512 rejected");
    send(3'd0, 5'd2, 14'd511, 6'd0, 3'd0, 8'd0, "R7 row 511 sent");
    send(3'd0, 5'd4, 14'h3FFF, 6'd0, 3'd0, 8'd0, "R7 row max rejected");
    idle(3);
    send(3'd6, 5'd1, '0, 6'd1, 3'd1, 8'h11, "R11 code6");
    send(3'd7, 5'd1, '0, 6'd1, 3'd1, 8'h11, "R11 code7");
    @(negedge clk);
    req_valid = 1'b0;
    chk(!cke && !row_err, "R11 dropped code sends nothing", {cke, row_err}, 0);
    @(negedge clk);
    chk(!cke && !row_err, "R11 dropped code sends nothing", {cke, row_err}, 0);
    // acceptance gap check: ready low during beat0
    send(3'd1, 5'd12, '0, 6'd33, 3'd0, 8'd0, "R2 read bank12");
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && cke, "R10 ready low in beat0", {req_ready, cke}, 2'b01);
    idle(4);
    chk(exp_q.size() == 0, "R2 all expected packets seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule